// File: doc/BRIEF.md
# Serial Port Status and Interrupt Controller

This block holds the status flags of a serial transceiver and turns them into interrupt request lines. It follows four conditions: transmit holding register empty, transmitter idle (last frame sent), receive holding register full, and receive overrun. Each condition is ANDed with an enable bit. One receive enable covers both receive requests, and the transmit-empty and transmit-idle requests each have their own enable bit.

The block also owns the transmit and receive enable bits. It refuses any write that would move the port into full-duplex operation along an unsafe path. An external bus decoder supplies write and read strobes. A shift engine reports when it takes a byte, when the last bit leaves, and when a frame arrives. The block tells the shift engine when transmit data is waiting, and tells the receive data register when to capture a frame.

Top module: `ser_status_irq`

## Requirements
- R1: After reset the status word `stat_o` (bit 0 tx empty, bit 1 tx idle, bit 2 rx full, bit 3 overrun, bit 4 illegal-switch) reads 5'b00011, `ctrl_o` reads 0 and all four requests are low.
- R2: Each request is a level equal to its flag AND its enable. The control bits are bit 0 tx-empty enable, bit 1 receive enable (covers rx full and overrun), bit 2 transmitter on, bit 3 receiver on, bit 4 tx-idle enable. A request follows, in the same cycle, the register update of its flag or its enable.
- R3: Because tx empty is 1 after reset, setting the tx-empty enable raises `irq_tx_empty` on the cycle after the write, with no data written.
- R4: A `tdr_wr` pulse clears tx empty and tx idle on the next cycle. `tx_req` is high while the transmitter is on and tx empty is 0.
- R5: `shf_load` sets tx empty. `shf_done` sets tx idle only when tx empty is 1. If `tdr_wr` and `shf_load` occur in the same cycle, tx empty ends up 0.
- R6: When the receiver is on, `shf_frame` with rx full at 0 pulses `rx_store` in that cycle and sets rx full. When the receiver is off, frames are ignored.
- R7: A frame that arrives while rx full is 1 and the register is not being read sets overrun, gives no `rx_store`, and leaves rx full at 1.
- R8: `rdr_rd` clears rx full. A frame that arrives in the same cycle as the read is stored and leaves rx full at 1.
- R9: Overrun is cleared only by `stat_wr` with `stat_wdata_ovr`=0, and only after a `stat_rd` that saw overrun at 1. Without that read, or with the data bit at 1, the write has no effect.
- R10: A control write that requests full duplex (bits 3:2 = 11) directly from transmit-only or receive-only is discarded entirely, and the sticky illegal-switch bit is set.
- R11: Entering full duplex from the all-off state needs tx empty=1, tx idle=1, rx full=0 and overrun=0. Otherwise the write is discarded and the illegal-switch bit is set.
- R12: All other control writes take effect on the next cycle. This includes turning the transmitter or receiver off at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 5 | Control write data |
| stat_rd | input | 1 | Status register read strobe |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata_ovr | input | 1 | Overrun bit of the status write data |
| tdr_wr | input | 1 | Transmit data register written |
| rdr_rd | input | 1 | Receive data register read |
| shf_load | input | 1 | Shift engine took the transmit byte |
| shf_done | input | 1 | Last bit of a frame has left |
| shf_frame | input | 1 | A received frame is complete |
| ctrl_o | output | 5 | Control register contents |
| stat_o | output | 5 | Status flags |
| tx_req | output | 1 | Transmit data waiting for the shifter |
| rx_store | output | 1 | Capture strobe for the receive data register |
| irq_rx_full | output | 1 | Receive full request |
| irq_tx_empty | output | 1 | Transmit empty request |
| irq_tx_end | output | 1 | Transmit idle request |
| irq_rx_err | output | 1 | Overrun request |

## Verification
The assertions check several rules on every cycle. A disabled enable keeps its request low. A data write empties the transmit side. Overrun can rise only on a frame that arrives while the register is full, and can fall only through the status write. The illegal-switch bit never clears, and a direct jump into duplex leaves the control bits untouched. The directed scenarios are needed for the rest. They show the early transmit request after reset, the same-cycle priorities of write against load and read against frame, the read-then-write clearing handshake, and the flag conditions that decide whether a switch from the all-off state is accepted.

// File: rtl/ssi_pkg.sv
// Package: shared field positions and mode encoding for the serial
// status and interrupt controller. Assumes 5-bit control and status words.
package ssi_pkg;
    localparam int CTRL_W = 5;
    localparam int STAT_W = 5;
    localparam int N_IRQ  = 4;

    // control word bit positions
    localparam int C_TXIE = 0;
    localparam int C_RXIE = 1;
    localparam int C_TXEN = 2;
    localparam int C_RXEN = 3;
    localparam int C_TEIE = 4;

    // status word bit positions
    localparam int S_TXE  = 0;
    localparam int S_TEND = 1;
    localparam int S_RXF  = 2;
    localparam int S_OVR  = 3;
    localparam int S_ILL  = 4;

    // request vector positions
    localparam int Q_RXF  = 0;
    localparam int Q_TXE  = 1;
    localparam int Q_TEND = 2;
    localparam int Q_OVR  = 3;

    // operating mode, encoded as {receiver on, transmitter on}
    typedef enum logic [1:0] {
        MODE_OFF    = 2'b00,
        MODE_TX     = 2'b01,
        MODE_RX     = 2'b10,
        MODE_DUPLEX = 2'b11
    } mode_e;

    function automatic mode_e mode_of(input logic [CTRL_W-1:0] c);
        return mode_e'({c[C_RXEN], c[C_TXEN]});
    endfunction
endpackage

// File: rtl/ssi_mode_guard.sv
// Module: holds the control word and screens each write for an unsafe
// move into full duplex. Assumes flag inputs are the registered status.
module ssi_mode_guard
    import ssi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              txe,
    input  logic              tend,
    input  logic              rxf,
    input  logic              ovr,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              illegal_q
);
    mode_e cur_mode;
    mode_e new_mode;
    logic  quiet;
    logic  bad;

    // classify the requested mode change
    always_comb begin
        cur_mode = mode_of(ctrl_q);
        new_mode = mode_of(wdata);
        quiet    = txe && tend && !rxf && !ovr;
        bad      = (new_mode == MODE_DUPLEX) && (cur_mode != MODE_DUPLEX) &&
                   ((cur_mode != MODE_OFF) || !quiet);
    end

    // update control word, or record a refused write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            illegal_q <= 1'b0;
        end else if (wr) begin
            if (bad) illegal_q <= 1'b1;
            else     ctrl_q    <= wdata;
        end
    end
endmodule

// File: rtl/ssi_tx_flags.sv
// Module: transmit-empty and transmit-idle flags. Assumes the shifter
// reports each byte take and each final bit once per event.
module ssi_tx_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic tdr_wr,
    input  logic shf_load,
    input  logic shf_done,
    output logic txe,
    output logic tend
);
    // a data write outranks a load in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txe  <= 1'b1;
            tend <= 1'b1;
        end else if (tdr_wr) begin
            txe  <= 1'b0;
            tend <= 1'b0;
        end else begin
            if (shf_load)        txe  <= 1'b1;
            if (shf_done && txe) tend <= 1'b1;
        end
    end
endmodule

// File: rtl/ssi_rx_flags.sv
// Module: receive-full and overrun flags with the read-then-write
// overrun clearing handshake. Assumes one strobe per received frame.
module ssi_rx_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_en,
    input  logic shf_frame,
    input  logic rdr_rd,
    input  logic stat_rd,
    input  logic stat_wr,
    input  logic stat_wdata_ovr,
    output logic rxf,
    output logic ovr,
    output logic rx_store
);
    logic accept;
    logic room;
    logic ovr_ev;
    logic ovr_clr;
    logic armed;

    // decide between storing and overrunning
    always_comb begin
        accept   = shf_frame && rx_en;
        room     = !rxf || rdr_rd;
        rx_store = accept && room;
        ovr_ev   = accept && !room;
        ovr_clr  = stat_wr && !stat_wdata_ovr && armed;
    end

    // receive-full: a store wins over a read
    always_ff @(posedge clk) begin
        if (!rst_n)        rxf <= 1'b0;
        else if (rx_store) rxf <= 1'b1;
        else if (rdr_rd)   rxf <= 1'b0;
    end

    // arm the clear once overrun has been read as set
    always_ff @(posedge clk) begin
        if (!rst_n)              armed <= 1'b0;
        else if (ovr_clr)        armed <= 1'b0;
        else if (stat_rd && ovr) armed <= 1'b1;
    end

    // overrun: a new overrun wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n)       ovr <= 1'b0;
        else if (ovr_ev)  ovr <= 1'b1;
        else if (ovr_clr) ovr <= 1'b0;
    end
endmodule

// File: rtl/ssi_irq_gate.sv
// Module: level requests as flag AND enable, one lane per source.
// Assumes flags and enables are registered.
module ssi_irq_gate #(
    parameter int N = 4
) (
    input  logic [N-1:0] flags,
    input  logic [N-1:0] enables,
    output logic [N-1:0] irq
);
    for (genvar i = 0; i < N; i++) begin : g_lane
        // one request lane
        assign irq[i] = flags[i] & enables[i];
    end
endmodule

// File: rtl/ser_status_irq.sv
// Module: top of the serial status and interrupt controller. Wires the
// mode guard, flag blocks and request gate. Assumes single-cycle strobes.
module ser_status_irq
    import ssi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              stat_rd,
    input  logic              stat_wr,
    input  logic              stat_wdata_ovr,
    input  logic              tdr_wr,
    input  logic              rdr_rd,
    input  logic              shf_load,
    input  logic              shf_done,
    input  logic              shf_frame,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [STAT_W-1:0] stat_o,
    output logic              tx_req,
    output logic              rx_store,
    output logic              irq_rx_full,
    output logic              irq_tx_empty,
    output logic              irq_tx_end,
    output logic              irq_rx_err
);
    logic              txe, tend, rxf, ovr, illegal;
    logic [CTRL_W-1:0] ctrl;
    logic [N_IRQ-1:0]  flag_v, en_v, irq_v;

    ssi_mode_guard u_guard (
        .clk(clk), .rst_n(rst_n), .wr(ctrl_wr), .wdata(ctrl_wdata),
        .txe(txe), .tend(tend), .rxf(rxf), .ovr(ovr),
        .ctrl_q(ctrl), .illegal_q(illegal)
    );

    ssi_tx_flags u_tx (
        .clk(clk), .rst_n(rst_n), .tdr_wr(tdr_wr), .shf_load(shf_load),
        .shf_done(shf_done), .txe(txe), .tend(tend)
    );

    ssi_rx_flags u_rx (
        .clk(clk), .rst_n(rst_n), .rx_en(ctrl[C_RXEN]), .shf_frame(shf_frame),
        .rdr_rd(rdr_rd), .stat_rd(stat_rd), .stat_wr(stat_wr),
        .stat_wdata_ovr(stat_wdata_ovr), .rxf(rxf), .ovr(ovr),
        .rx_store(rx_store)
    );

    // map flags and enables onto request lanes
    always_comb begin
        flag_v         = '0;
        en_v           = '0;
        flag_v[Q_RXF]  = rxf;
        flag_v[Q_TXE]  = txe;
        flag_v[Q_TEND] = tend;
        flag_v[Q_OVR]  = ovr;
        en_v[Q_RXF]    = ctrl[C_RXIE];
        en_v[Q_TXE]    = ctrl[C_TXIE];
        en_v[Q_TEND]   = ctrl[C_TEIE];
        en_v[Q_OVR]    = ctrl[C_RXIE];
    end

    ssi_irq_gate #(.N(N_IRQ)) u_gate (
        .flags(flag_v), .enables(en_v), .irq(irq_v)
    );

    // drive the outputs
    always_comb begin
        ctrl_o         = ctrl;
        stat_o         = '0;
        stat_o[S_TXE]  = txe;
        stat_o[S_TEND] = tend;
        stat_o[S_RXF]  = rxf;
        stat_o[S_OVR]  = ovr;
        stat_o[S_ILL]  = illegal;
        tx_req         = ctrl[C_TXEN] && !txe;
        irq_rx_full    = irq_v[Q_RXF];
        irq_tx_empty   = irq_v[Q_TXE];
        irq_tx_end     = irq_v[Q_TEND];
        irq_rx_err     = irq_v[Q_OVR];
    end
endmodule

// File: rtl/ser_status_irq_chk.sv
// Module: property checker bound to the controller top. Assumes the
// port encodings given in the brief.
module ser_status_irq_chk
    import ssi_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ctrl_wr,
    input logic [CTRL_W-1:0] ctrl_wdata,
    input logic              stat_wr,
    input logic              stat_wdata_ovr,
    input logic              tdr_wr,
    input logic              shf_frame,
    input logic [CTRL_W-1:0] ctrl_o,
    input logic [STAT_W-1:0] stat_o,
    input logic              rx_store,
    input logic              irq_rx_full,
    input logic              irq_tx_empty,
    input logic              irq_tx_end,
    input logic              irq_rx_err
);
    p_txie_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_o[C_TXIE] |-> !irq_tx_empty);
    p_rxie_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_o[C_RXIE] |-> (!irq_rx_full && !irq_rx_err));
    p_teie_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_o[C_TEIE] |-> !irq_tx_end);
    p_write_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tdr_wr |=> (!stat_o[S_TXE] && !stat_o[S_TEND]));
    p_store_needs_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_store |-> ctrl_o[C_RXEN]);
    p_ovr_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_o[S_OVR]) |-> ($past(shf_frame) && $past(stat_o[S_RXF])));
    p_ovr_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_o[S_OVR]) |-> ($past(stat_wr) && !$past(stat_wdata_ovr)));
    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stat_o[S_ILL] |=> stat_o[S_ILL]);
    p_direct_duplex_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && (ctrl_wdata[C_RXEN:C_TXEN] == 2'b11) &&
         (ctrl_o[C_RXEN] != ctrl_o[C_TXEN]))
        |=> ($stable(ctrl_o) && stat_o[S_ILL]));
endmodule

bind ser_status_irq ser_status_irq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .stat_wr(stat_wr), .stat_wdata_ovr(stat_wdata_ovr), .tdr_wr(tdr_wr),
    .shf_frame(shf_frame), .ctrl_o(ctrl_o), .stat_o(stat_o),
    .rx_store(rx_store), .irq_rx_full(irq_rx_full),
    .irq_tx_empty(irq_tx_empty), .irq_tx_end(irq_tx_end),
    .irq_rx_err(irq_rx_err)
);

// File: tb/tb_ser_status_irq.sv
`timescale 1ns/1ps
module tb_ser_status_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_wr = 0, stat_rd = 0, stat_wr = 0, stat_wdata_ovr = 0;
    logic       tdr_wr = 0, rdr_rd = 0, shf_load = 0, shf_done = 0, shf_frame = 0;
    logic [4:0] ctrl_wdata = '0;
    logic [4:0] ctrl_o, stat_o;
    logic       tx_req, rx_store, irq_rx_full, irq_tx_empty, irq_tx_end, irq_rx_err;
    int         n_chk = 0, n_err = 0;

    always #2.5 clk = ~clk;

    ser_status_irq dut (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .stat_rd(stat_rd), .stat_wr(stat_wr), .stat_wdata_ovr(stat_wdata_ovr),
        .tdr_wr(tdr_wr), .rdr_rd(rdr_rd), .shf_load(shf_load),
        .shf_done(shf_done), .shf_frame(shf_frame), .ctrl_o(ctrl_o),
        .stat_o(stat_o), .tx_req(tx_req), .rx_store(rx_store),
        .irq_rx_full(irq_rx_full), .irq_tx_empty(irq_tx_empty),
        .irq_tx_end(irq_tx_end), .irq_rx_err(irq_rx_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // end a cycle: let one rising edge pass, then drop all strobes
    task automatic tick();
        @(negedge clk);
        ctrl_wr = 0; stat_rd = 0; stat_wr = 0; stat_wdata_ovr = 0;
        tdr_wr = 0; rdr_rd = 0; shf_load = 0; shf_done = 0; shf_frame = 0;
    endtask

    task automatic wr_ctrl(input logic [4:0] v);
        ctrl_wr = 1; ctrl_wdata = v; tick();
    endtask

    task automatic do_reset();
        rst_n = 0; tick(); tick(); rst_n = 1; tick();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 stat", stat_o, 5'b00011);
        chk("R1 ctrl", ctrl_o, 0);
        chk("R1 irqs", {irq_rx_full, irq_tx_empty, irq_tx_end, irq_rx_err}, 0);
    endtask

    task automatic t_early_irq();
        do_reset();
        wr_ctrl(5'h01);
        chk("R3 tx empty request without data", irq_tx_empty, 1);
        wr_ctrl(5'h11);
        chk("R2 tx idle request", irq_tx_end, 1);
        wr_ctrl(5'h00);
        chk("R2 requests drop with enables", {irq_tx_empty, irq_tx_end}, 0);
    endtask

    task automatic t_tx_path();
        do_reset();
        wr_ctrl(5'h15);
        tdr_wr = 1; tick();
        chk("R4 flags cleared", stat_o[1:0], 2'b00);
        chk("R4 tx_req", tx_req, 1);
        chk("R2 tx requests low", {irq_tx_empty, irq_tx_end}, 0);
        shf_load = 1; tick();
        chk("R5 load sets empty", stat_o[1:0], 2'b01);
        chk("R4 tx_req drops", tx_req, 0);
        shf_done = 1; tick();
        chk("R5 done sets idle", stat_o[1:0], 2'b11);
        chk("R2 tx idle request", irq_tx_end, 1);
        tdr_wr = 1; shf_load = 1; tick();
        chk("R5 write beats load", stat_o[1:0], 2'b00);
        shf_done = 1; tick();
        chk("R5 done ignored while data pending", stat_o[1], 0);
        shf_load = 1; tick();
        shf_done = 1; tick();
        chk("R5 second frame ends idle", stat_o[1:0], 2'b11);
    endtask

    task automatic t_modes();
        do_reset();
        wr_ctrl(5'h04);
        chk("R12 tx-only accepted", ctrl_o, 5'h04);
        wr_ctrl(5'h0C);
        chk("R10 tx to duplex refused", ctrl_o, 5'h04);
        chk("R10 illegal set", stat_o[4], 1);
        wr_ctrl(5'h00);
        chk("R10 illegal stays set", stat_o[4], 1);
        do_reset();
        wr_ctrl(5'h04);
        tdr_wr = 1; tick();
        wr_ctrl(5'h00);
        chk("R12 tx off while busy", ctrl_o, 5'h00);
        wr_ctrl(5'h0C);
        chk("R11 duplex refused while tx busy", {stat_o[4], ctrl_o}, {1'b1, 5'h00});
        do_reset();
        wr_ctrl(5'h04);
        wr_ctrl(5'h00);
        wr_ctrl(5'h0C);
        chk("R11 duplex via off accepted", {stat_o[4], ctrl_o}, {1'b0, 5'h0C});
        do_reset();
        wr_ctrl(5'h08);
        wr_ctrl(5'h0C);
        chk("R10 rx to duplex refused", {stat_o[4], ctrl_o}, {1'b1, 5'h08});
        do_reset();
        wr_ctrl(5'h08);
        shf_frame = 1; tick();
        wr_ctrl(5'h00);
        wr_ctrl(5'h0C);
        chk("R11 duplex refused while rx full", {stat_o[4], ctrl_o}, {1'b1, 5'h00});
    endtask

    task automatic t_rx_path();
        do_reset();
        shf_frame = 1; #1;
        chk("R6 no store while rx off", rx_store, 0);
        tick();
        chk("R6 frame ignored while rx off", stat_o[2], 0);
        wr_ctrl(5'h0A);
        shf_frame = 1; #1;
        chk("R6 store strobe", rx_store, 1);
        tick();
        chk("R6 rx full", stat_o[2], 1);
        chk("R2 rx full request", irq_rx_full, 1);
        shf_frame = 1; #1;
        chk("R7 no store on overrun", rx_store, 0);
        tick();
        chk("R7 overrun set, full kept", stat_o[3:2], 2'b11);
        chk("R2 error request on rx enable", irq_rx_err, 1);
        rdr_rd = 1; tick();
        chk("R8 read clears full", stat_o[2], 0);
        shf_frame = 1; tick();
        shf_frame = 1; rdr_rd = 1; #1;
        chk("R8 frame with read stored", rx_store, 1);
        tick();
        chk("R8 full kept after read+frame", stat_o[2], 1);
        stat_wr = 1; stat_wdata_ovr = 0; tick();
        chk("R9 clear without read ignored", stat_o[3], 1);
        stat_rd = 1; tick();
        stat_wr = 1; stat_wdata_ovr = 1; tick();
        chk("R9 write of one ignored", stat_o[3], 1);
        stat_wr = 1; stat_wdata_ovr = 0; tick();
        chk("R9 overrun cleared", stat_o[3], 0);
        chk("R2 error request dropped", irq_rx_err, 0);
        wr_ctrl(5'h08);
        chk("R2 rx enable off drops request", irq_rx_full, 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_early_irq();
                t_tx_path();
                t_modes();
                t_rx_path();
            end
            begin
                repeat (200000) @(posedge clk);
                n_err++; n_chk++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule